// File: doc/BRIEF.md
# Filtered External Event Counter

This block counts transitions on an asynchronous external input pin. The raw pin is first brought into the system clock domain by a short flop chain, then examined by a sampled noise filter that looks at it once every eight system clocks. A new level is believed only when two consecutive samples agree on it. Short glitches are therefore dropped before they reach the counter. The filtered level produces rising and falling pulses, and a 2-bit edge selector decides which of them advance the counter.

A compare register sets the count period. When a selected edge arrives while the count already equals the compare value, the counter returns to zero instead of advancing, and a one-cycle interrupt pulse is produced. The counter runs only while the mode input requests clear-and-start on match. In every other mode it is held at zero. A compare value of zero is refused, so the period can never collapse.

Top module: `filt_event_counter`

## Requirements
- R1: While `mode_i` is 11, `count_o` (CNT_W bits) rises by exactly one for each selected edge of the filtered input. It changes at no other time, except when it clears to zero.
- R2: `edge_sel_i` picks the counted edge: 00 counts falling edges, 01 counts rising edges and 11 counts both. The reserved value 10 counts nothing.
- R3: The synchronised pin is sampled every 2^DIV_LOG2 (8) system clocks. The filtered level changes only in the cycle after a sample, and only when AGREE (2) consecutive samples show the new level. A pulse shorter than one sample period never changes the count.
- R4: The first sample after reset loads the filtered level directly and produces no edge, whatever the pin level is.
- R5: When a selected edge arrives while `count_o` equals the compare value, `count_o` becomes zero and `irq_o` is high for exactly one cycle. That is the same cycle in which `count_o` first shows zero. `irq_o` is never high otherwise.
- R6: The compare register resets to all ones. A write with `cmp_wr_i` high loads `cmp_val_i`, except that a value of zero is ignored and the previous value is kept.
- R7: While `mode_i` is not 11, `count_o` is zero from the next cycle on, and edges are not counted.
- R8: If the compare value is set below the current count, counting continues. The counter wraps from all ones to zero with no interrupt, then matches the compare value normally.
- R9: After reset `count_o` is zero and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_pin_i | input | 1 | Raw asynchronous event input |
| edge_sel_i | input | 2 | Counted edge: 00 falling, 01 rising, 10 reserved, 11 both |
| mode_i | input | 2 | Operating mode; 11 runs the counter, others hold it at zero |
| cmp_val_i | input | CNT_W | Compare value to load |
| cmp_wr_i | input | 1 | Compare write strobe |
| count_o | output | CNT_W | Current count |
| irq_o | output | 1 | One-cycle interrupt on compare match |

## Verification
The bench builds the block with CNT_W set to 6 and keeps the default sample divider and agreement depth. The narrow counter puts the reset compare value of all ones, and the wrap from all ones to zero, within a few dozen edges. At the full 16-bit width, 65536 edges would be needed. It also makes the below-count compare case practical to run many times among the random steps.

// File: rtl/efc_pkg.sv
package efc_pkg;

    typedef enum logic [1:0] {
        EDGE_FALL = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_RSVD = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_sel_e;

    typedef enum logic [1:0] {
        MODE_STOP0 = 2'b00,
        MODE_STOP1 = 2'b01,
        MODE_STOP2 = 2'b10,
        MODE_RUN   = 2'b11
    } mode_e;

endpackage

// File: rtl/efc_sync.sv
module efc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = STAGES'({chain_q, async_i});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/efc_prescaler.sv
module efc_prescaler #(
    parameter int DIV_LOG2 = 3
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    logic [DIV_LOG2-1:0] div_d, div_q;

    always_comb begin
        div_d = div_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    assign tick_o = &div_q;
endmodule

// File: rtl/efc_filter.sv
module efc_filter #(
    parameter int AGREE = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic pin_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int HW = AGREE - 1;
    localparam int FW = $clog2(HW + 1);
    localparam logic [FW-1:0] FILL_FULL = FW'(HW);

    typedef struct packed {
        logic [HW-1:0] hist;
        logic [FW-1:0] fill;
        logic          level;
        logic          valid;
        logic          rise;
        logic          fall;
    } filt_t;

    filt_t st_d, st_q;
    logic  agree;

    always_comb begin
        st_d      = st_q;
        st_d.rise = 1'b0;
        st_d.fall = 1'b0;
        agree     = (st_q.hist == {HW{pin_i}}) && (st_q.fill == FILL_FULL);
        if (tick_i) begin
            st_d.hist = HW'({st_q.hist, pin_i});
            if (st_q.fill != FILL_FULL) st_d.fill = st_q.fill + 1'b1;
            if (!st_q.valid) begin
                st_d.level = pin_i;
                st_d.valid = 1'b1;
            end else if (agree && (pin_i != st_q.level)) begin
                st_d.level = pin_i;
                st_d.rise  = pin_i;
                st_d.fall  = ~pin_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level_o = st_q.level;
    assign rise_o  = st_q.rise;
    assign fall_o  = st_q.fall;
endmodule

// File: rtl/efc_count.sv
module efc_count
    import efc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise_i,
    input  logic             fall_i,
    input  logic [1:0]       edge_sel_i,
    input  logic [1:0]       mode_i,
    input  logic [CNT_W-1:0] cmp_val_i,
    input  logic             cmp_wr_i,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W-1:0] cmp_o,
    output logic             irq_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] cmp;
        logic             irq;
    } cnt_t;

    cnt_t      st_d, st_q;
    logic      hit;
    edge_sel_e sel;

    always_comb begin
        sel = edge_sel_e'(edge_sel_i);
        unique case (sel)
            EDGE_FALL: hit = fall_i;
            EDGE_RISE: hit = rise_i;
            EDGE_BOTH: hit = rise_i | fall_i;
            default:   hit = 1'b0;
        endcase
    end

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        if (cmp_wr_i && (cmp_val_i != '0)) st_d.cmp = cmp_val_i;
        if (mode_e'(mode_i) != MODE_RUN) begin
            st_d.cnt = '0;
        end else if (hit) begin
            if (st_q.cnt == st_q.cmp) begin
                st_d.cnt = '0;
                st_d.irq = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= '0;
            st_q.cmp <= '1;
            st_q.irq <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o = st_q.cnt;
    assign cmp_o   = st_q.cmp;
    assign irq_o   = st_q.irq;
endmodule

// File: rtl/filt_event_counter.sv
module filt_event_counter #(
    parameter int CNT_W       = 16,
    parameter int DIV_LOG2    = 3,
    parameter int SYNC_STAGES = 2,
    parameter int AGREE       = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_pin_i,
    input  logic [1:0]       edge_sel_i,
    input  logic [1:0]       mode_i,
    input  logic [CNT_W-1:0] cmp_val_i,
    input  logic             cmp_wr_i,
    output logic [CNT_W-1:0] count_o,
    output logic             irq_o
);
    logic             pin_sync;
    logic             samp_tick;
    logic             filt_level;
    logic             filt_rise;
    logic             filt_fall;
    logic [CNT_W-1:0] cmp_q;

    efc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (evt_pin_i),
        .sync_o  (pin_sync)
    );

    efc_prescaler #(.DIV_LOG2(DIV_LOG2)) u_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (samp_tick)
    );

    efc_filter #(.AGREE(AGREE)) u_filt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (samp_tick),
        .pin_i   (pin_sync),
        .level_o (filt_level),
        .rise_o  (filt_rise),
        .fall_o  (filt_fall)
    );

    efc_count #(.CNT_W(CNT_W)) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .rise_i     (filt_rise),
        .fall_i     (filt_fall),
        .edge_sel_i (edge_sel_i),
        .mode_i     (mode_i),
        .cmp_val_i  (cmp_val_i),
        .cmp_wr_i   (cmp_wr_i),
        .count_o    (count_o),
        .cmp_o      (cmp_q),
        .irq_o      (irq_o)
    );
endmodule

// File: rtl/efc_checker.sv
module efc_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       mode_i,
    input logic [CNT_W-1:0] cmp_val_i,
    input logic             cmp_wr_i,
    input logic [CNT_W-1:0] count_o,
    input logic             irq_o,
    input logic [CNT_W-1:0] cmp_q,
    input logic             samp_tick,
    input logic             filt_level
);
    a_r5_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

    a_r5_irq_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (count_o == '0));

    a_r7_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i != 2'b11) |=> (count_o == '0));

    a_r1_step_or_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (count_o != $past(count_o)) |-> ((count_o == $past(count_o) + 1'b1) || (count_o == '0)));

    a_r6_zero_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_wr_i && (cmp_val_i == '0)) |=> $stable(cmp_q));

    a_r6_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_wr_i && (cmp_val_i != '0)) |=> (cmp_q == $past(cmp_val_i)));

    a_r3_change_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_level != $past(filt_level)) |-> $past(samp_tick));
endmodule

bind filt_event_counter efc_checker #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_i     (mode_i),
    .cmp_val_i  (cmp_val_i),
    .cmp_wr_i   (cmp_wr_i),
    .count_o    (count_o),
    .irq_o      (irq_o),
    .cmp_q      (cmp_q),
    .samp_tick  (samp_tick),
    .filt_level (filt_level)
);

// File: tb/filt_event_counter_test.sv
module filt_event_counter_test;
    localparam int W = 6;
    localparam logic [W-1:0] MASK = '1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         pin = 1'b1;
    logic [1:0]   esel = 2'b11;
    logic [1:0]   mode = 2'b00;
    logic [W-1:0] cval = '0;
    logic         cwr = 1'b0;
    logic [W-1:0] count;
    logic         irq;

    int checks = 0;
    int errors = 0;
    int irq_seen = 0;
    int irq_wide = 0;
    logic irq_prev = 1'b0;
    bit   done = 1'b0;

    logic [W-1:0] exp_cnt = '0;
    logic [W-1:0] exp_cmp = '1;
    int           exp_irq = 0;
    logic         lvl = 1'b1;

    always #5 clk = ~clk;

    filt_event_counter #(.CNT_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .evt_pin_i(pin), .edge_sel_i(esel),
        .mode_i(mode), .cmp_val_i(cval), .cmp_wr_i(cwr),
        .count_o(count), .irq_o(irq)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (irq) irq_seen++;
            if (irq && irq_prev) irq_wide++;
            irq_prev <= irq;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (32) @(negedge clk);
    endtask

    function automatic logic edge_counts(input logic [1:0] s, input logic rising);
        return (s == 2'b01 && rising) || (s == 2'b00 && !rising) || (s == 2'b11);
    endfunction

    task automatic model_edge(input logic rising);
        if (mode == 2'b11 && edge_counts(esel, rising)) begin
            if (exp_cnt == exp_cmp) begin
                exp_cnt = '0;
                exp_irq++;
            end else begin
                exp_cnt = (exp_cnt + 1'b1) & MASK;
            end
        end
    endtask

    task automatic set_level(input logic v);
        @(negedge clk) pin = v;
        settle();
        if (v != lvl) begin
            model_edge(v);
            lvl = v;
        end
    endtask

    task automatic glitch();
        @(negedge clk) pin = ~lvl;
        repeat (5) @(negedge clk);
        pin = lvl;
        settle();
    endtask

    task automatic write_cmp(input logic [W-1:0] v);
        @(negedge clk) begin cval = v; cwr = 1'b1; end
        @(negedge clk) cwr = 1'b0;
        if (v != '0) exp_cmp = v;
    endtask

    task automatic set_mode(input logic [1:0] m);
        @(negedge clk) mode = m;
        @(negedge clk);
        if (m != 2'b11) exp_cnt = '0;
    endtask

    task automatic check_state(input string req);
        chk(req, int'(count), int'(exp_cnt));
        chk({req, " irq count"}, irq_seen, exp_irq);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        // R9: reset state
        chk("R9 count after reset", int'(count), 0);
        chk("R9 irq after reset", int'(irq), 0);
        rst_n = 1'b1;
        mode = 2'b11;
        // R4: pin high at first sample must not create an edge
        settle();
        chk("R4 no edge from first sample", int'(count), 0);

        // R6 reset compare is all ones, R5 match, R1 counting, both edges
        for (int i = 0; i < 63; i++) set_level(~lvl);
        chk("R6 reset compare all ones", int'(count), 63);
        chk("R5 no irq before match", irq_seen, 0);
        set_level(~lvl);
        chk("R5 clear on match", int'(count), 0);
        chk("R5 one irq on match", irq_seen, 1);
        chk("R5 irq single cycle", irq_wide, 0);

        // R3 glitches rejected
        glitch(); glitch();
        chk("R3 glitch ignored", int'(count), int'(exp_cnt));

        // R2 edge selection
        esel = 2'b01; set_level(~lvl); set_level(~lvl);
        check_state("R2 rising only");
        esel = 2'b00; set_level(~lvl); set_level(~lvl);
        check_state("R2 falling only");
        esel = 2'b10; set_level(~lvl); set_level(~lvl);
        chk("R2 reserved counts nothing", int'(count), int'(exp_cnt));

        // R6 zero write ignored, then a small period
        esel = 2'b11;
        write_cmp(6'd3);
        write_cmp(6'd0);
        set_mode(2'b00);
        chk("R7 stopped holds zero", int'(count), 0);
        set_level(~lvl); set_level(~lvl);
        chk("R7 edges ignored when stopped", int'(count), 0);
        set_mode(2'b11);
        for (int i = 0; i < 5; i++) set_level(~lvl);
        check_state("R6 zero write kept period 3");

        // R8 compare below count wraps with no irq
        write_cmp(6'd40);
        set_mode(2'b00); set_mode(2'b11);
        for (int i = 0; i < 20; i++) set_level(~lvl);
        chk("R1 count 20", int'(count), 20);
        write_cmp(6'd5);
        for (int i = 0; i < 44; i++) set_level(~lvl);
        chk("R8 wrapped to zero", int'(count), 0);
        chk("R8 no irq on wrap", irq_seen, exp_irq);
        for (int i = 0; i < 6; i++) set_level(~lvl);
        chk("R8 then matches", int'(count), 0);
        check_state("R8 model");

        // random phase
        for (int it = 0; it < 300; it++) begin
            int r = int'($urandom_range(99));
            if (r < 60)      set_level(~lvl);
            else if (r < 70) glitch();
            else if (r < 80) esel = 2'($urandom_range(3));
            else if (r < 92) write_cmp(W'($urandom_range(12)));
            else             set_mode(($urandom_range(3) == 0) ? 2'b01 : 2'b11);
            check_state("R1 R2 R3 R5 R6 R7 random");
        end
        set_mode(2'b11);
        check_state("R7 resume");
        chk("R5 irq never wide", irq_wide, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule